// File: doc/BRIEF.md
# Quadrant-Folded Polynomial Sine Evaluator

This block turns an unsigned phase word into a signed two's complement sine sample for a DAC. The phase word spans one full turn: the value `p` stands for the angle 2π·p/2^PHASE_W. The top two phase bits pick the quadrant. The remaining bits are mirrored when the quadrant is odd, so the polynomial is only ever evaluated between 0 and π/2. The sign is then flipped for the second half of the turn.

The amplitude comes from an odd series of order fifteen. Its eight coefficients are fixed-point constants computed when the design is elaborated. The series is evaluated by Horner's rule in x² on a single shared multiply-add unit, which a small sequencer drives. The sequencer first scales the folded phase to radians, then squares it, then runs seven Horner steps, and finally multiplies by x. The result, normalised to the range −1..+1, is rounded to OUT_W bits. A result that rounds to +1.0 is clamped to the largest positive code.

Only one phase is in flight at a time. The phase input has a valid/ready pair, and the sample output holds until the consumer takes it.

Top module: `sine_poly_eval`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A phase is taken only when `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the resulting sample has been taken. A phase offered while `in_ready` is 0 is ignored and produces no sample.
- R3: `out_valid` goes to 1 exactly 10 clock edges (seven Horner steps plus three) after the edge that took the phase.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sample` does not change. The edge with `out_ready` at 1 retires the sample.
- R5: For phase `p`, `out_sample` is within 2 LSB of round(sin(2π·p/2^PHASE_W)·2^(OUT_W−1)), clipped to ±(2^(OUT_W−1)−1).
- R6: The sample for `p + 2^(PHASE_W−1)` is exactly the negation of the sample for `p`, for every `p` in the first half-turn.
- R7: The samples for `2^(PHASE_W−2) − d` and `2^(PHASE_W−2) + d` are exactly equal.
- R8: The phase for a quarter turn gives 2^(OUT_W−1)−1, and the phase for three quarters gives −(2^(OUT_W−1)−1). The code −2^(OUT_W−1) is never produced.
- R9: Phases 0 and 2^(PHASE_W−1) give exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A phase word is offered |
| in_ready | output | 1 | Block is idle and will take a phase |
| in_phase | input | PHASE_W | Unsigned phase, full turn = 2^PHASE_W |
| out_valid | output | 1 | A sample is held on `out_sample` |
| out_ready | input | 1 | Consumer takes the held sample |
| out_sample | output | OUT_W | Two's complement sine amplitude |

## Verification
The four cardinal phases pin down the exact behaviour at the fold boundaries. They show whether the quarter-turn reflection reaches exactly π/2, whether the saturation at the top code is applied, and whether a zero argument stays exactly zero in both half-turns. A scattered sweep across all quadrants measures the amplitude error against a real-valued sine. It separates a wrong coefficient, scale or rounding from a folding fault. Pairs of phases mirrored about the quarter point, and pairs half a turn apart, must match bit for bit, which isolates the reflection and sign logic from the arithmetic. Held-back output, phases offered while busy, and a measured accept-to-valid delay exercise the handshake.

// File: rtl/sine_poly_pkg.sv
package sine_poly_pkg;

   // Horner steps after the initial top coefficient load
   localparam int HORNER_STEPS = 7;
   localparam int NUM_COEF     = HORNER_STEPS + 1;
   // accept edge -> valid edge: radian scale, square, steps, final multiply
   localparam int ACCEPT_TO_VALID = HORNER_STEPS + 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RAD,
      ST_SQR,
      ST_HORN,
      ST_FIN,
      ST_HOLD
   } seq_state_e;

   // Coefficient k of the odd series in x^2: (-1)^k / (2k+1)!, scaled by 2^frac
   function automatic longint series_coef(input int k, input int frac);
      longint fact;
      longint num;
      longint val;
      fact = 1;
      for (int i = 2; i <= 2 * k + 1; i++) begin
         fact = fact * longint'(i);
      end
      num = longint'(1) <<< frac;
      val = (num + fact / 2) / fact;
      if ((k % 2) == 1) begin
         val = -val;
      end
      return val;
   endfunction

endpackage

// File: rtl/sine_phase_fold.sv
module sine_phase_fold #(
   parameter int PHASE_W = 16,
   parameter int FRAC    = 28,
   parameter int WORD_W  = 31
) (
   input  logic [PHASE_W-1:0]       phase,
   output logic                     negate,
   output logic signed [WORD_W-1:0] arg
);
   localparam int QB = PHASE_W - 2;

   logic [1:0]    quad;
   logic [QB-1:0] u_in;
   logic [QB:0]   u_ref;

   assign quad   = phase[PHASE_W-1 -: 2];
   assign u_in   = phase[QB-1:0];
   // second half-turn: sin(x) = -sin(x - pi)
   assign negate = quad[1];

   // odd quadrant: sin(x) = sin(pi - x), measured as 2^QB - u
   always_comb begin
      if (quad[0]) begin
         u_ref = (QB+1)'(1) << QB;
         u_ref = u_ref - {1'b0, u_in};
      end else begin
         u_ref = {1'b0, u_in};
      end
   end

   // fraction of a quarter turn, placed at FRAC fractional bits
   assign arg = WORD_W'(u_ref) << (FRAC - QB);

endmodule

// File: rtl/sine_fx_mac.sv
module sine_fx_mac #(
   parameter int WORD_W = 31,
   parameter int FRAC   = 28,
   parameter bit ROUND  = 1'b1
) (
   input  logic signed [WORD_W-1:0] mul_a,
   input  logic signed [WORD_W-1:0] mul_b,
   input  logic signed [WORD_W-1:0] add_c,
   output logic signed [WORD_W-1:0] res
);
   localparam int PW2 = 2 * WORD_W;

   logic signed [PW2-1:0] prod;
   logic signed [PW2-1:0] bias;
   logic signed [PW2-1:0] scaled;

   assign prod = $signed({{WORD_W{mul_a[WORD_W-1]}}, mul_a}) *
                 $signed({{WORD_W{mul_b[WORD_W-1]}}, mul_b});

   generate
      if (ROUND) begin : g_round
         assign bias = PW2'(longint'(1) <<< (FRAC - 1));
      end else begin : g_trunc
         assign bias = '0;
      end
   endgenerate

   assign scaled = (prod + bias) >>> FRAC;
   assign res    = scaled[WORD_W-1:0] + add_c;

endmodule

// File: rtl/sine_out_quant.sv
module sine_out_quant #(
   parameter int WORD_W = 31,
   parameter int FRAC   = 28,
   parameter int OUT_W  = 16,
   parameter bit ROUND  = 1'b1
) (
   input  logic signed [WORD_W-1:0] mag,
   input  logic                     negate,
   output logic [OUT_W-1:0]         code
);
   localparam int SH = FRAC - (OUT_W - 1);
   localparam logic signed [WORD_W-1:0] TOP_CODE =
      WORD_W'((longint'(1) <<< (OUT_W - 1)) - 1);

   logic signed [WORD_W-1:0] rounded;
   logic signed [WORD_W-1:0] clamped;
   logic [OUT_W-1:0]         mag_code;

   generate
      if (ROUND) begin : g_round
         localparam logic signed [WORD_W-1:0] HALF_LSB =
            WORD_W'(longint'(1) <<< (SH - 1));
         assign rounded = (mag + HALF_LSB) >>> SH;
      end else begin : g_trunc
         assign rounded = mag >>> SH;
      end
   endgenerate

   always_comb begin
      if (rounded < 0) begin
         clamped = '0;
      end else if (rounded > TOP_CODE) begin
         clamped = TOP_CODE;
      end else begin
         clamped = rounded;
      end
   end

   assign mag_code = clamped[OUT_W-1:0];
   assign code     = negate ? (~mag_code + OUT_W'(1)) : mag_code;

endmodule

// File: rtl/sine_poly_eval.sv
module sine_poly_eval
   import sine_poly_pkg::*;
#(
   parameter int PHASE_W        = 16,
   parameter int OUT_W          = 16,
   parameter int FRAC_BITS      = 28,
   parameter bit ROUND_PRODUCTS = 1'b1,
   parameter bit ROUND_OUTPUT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PHASE_W-1:0] in_phase,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [OUT_W-1:0]   out_sample
);
   localparam int WORD_W = FRAC_BITS + 3;
   localparam int STEP_W = $clog2(NUM_COEF);
   localparam logic signed [WORD_W-1:0] HALF_PI_FX =
      WORD_W'($rtoi(1.5707963267948966 * (2.0 ** FRAC_BITS) + 0.5));

   generate
      if (PHASE_W < 4) begin : g_chk_pw
         $error("PHASE_W must be at least 4");
      end
      if (OUT_W < 4) begin : g_chk_ow
         $error("OUT_W must be at least 4");
      end
      if (FRAC_BITS > 30) begin : g_chk_fmax
         $error("FRAC_BITS must not exceed 30");
      end
      if (FRAC_BITS < OUT_W + 4) begin : g_chk_fout
         $error("FRAC_BITS must exceed OUT_W by at least 4");
      end
      if (FRAC_BITS < PHASE_W - 2) begin : g_chk_fph
         $error("FRAC_BITS must hold the in-quadrant phase bits");
      end
   endgenerate

   logic signed [WORD_W-1:0] coef_tab [NUM_COEF];

   generate
      for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
         assign coef_tab[k] = WORD_W'(series_coef(k, FRAC_BITS));
      end
   endgenerate

   seq_state_e               state;
   logic signed [WORD_W-1:0] arg_q;
   logic signed [WORD_W-1:0] x_q;
   logic signed [WORD_W-1:0] y_q;
   logic signed [WORD_W-1:0] acc_q;
   logic [STEP_W-1:0]        step_q;
   logic                     neg_q;

   logic                     fold_neg;
   logic signed [WORD_W-1:0] fold_arg;
   logic signed [WORD_W-1:0] op_a;
   logic signed [WORD_W-1:0] op_b;
   logic signed [WORD_W-1:0] op_c;
   logic signed [WORD_W-1:0] mac_y;
   logic [OUT_W-1:0]         q_code;

   sine_phase_fold #(
      .PHASE_W (PHASE_W),
      .FRAC    (FRAC_BITS),
      .WORD_W  (WORD_W)
   ) u_fold (
      .phase   (in_phase),
      .negate  (fold_neg),
      .arg     (fold_arg)
   );

   always_comb begin
      op_a = acc_q;
      op_b = y_q;
      op_c = coef_tab[step_q];
      case (state)
         ST_RAD: begin
            op_a = arg_q;
            op_b = HALF_PI_FX;
            op_c = '0;
         end
         ST_SQR: begin
            op_a = x_q;
            op_b = x_q;
            op_c = '0;
         end
         ST_FIN: begin
            op_a = acc_q;
            op_b = x_q;
            op_c = '0;
         end
         default: ;
      endcase
   end

   sine_fx_mac #(
      .WORD_W (WORD_W),
      .FRAC   (FRAC_BITS),
      .ROUND  (ROUND_PRODUCTS)
   ) u_mac (
      .mul_a  (op_a),
      .mul_b  (op_b),
      .add_c  (op_c),
      .res    (mac_y)
   );

   sine_out_quant #(
      .WORD_W (WORD_W),
      .FRAC   (FRAC_BITS),
      .OUT_W  (OUT_W),
      .ROUND  (ROUND_OUTPUT)
   ) u_quant (
      .mag    (mac_y),
      .negate (neg_q),
      .code   (q_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         arg_q      <= '0;
         x_q        <= '0;
         y_q        <= '0;
         acc_q      <= '0;
         step_q     <= '0;
         neg_q      <= 1'b0;
         out_sample <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  arg_q <= fold_arg;
                  neg_q <= fold_neg;
                  state <= ST_RAD;
               end
            end
            ST_RAD: begin
               x_q   <= mac_y;
               state <= ST_SQR;
            end
            ST_SQR: begin
               y_q    <= mac_y;
               acc_q  <= coef_tab[NUM_COEF-1];
               step_q <= STEP_W'(NUM_COEF - 2);
               state  <= ST_HORN;
            end
            ST_HORN: begin
               acc_q <= mac_y;
               if (step_q == '0) begin
                  state <= ST_FIN;
               end else begin
                  step_q <= step_q - STEP_W'(1);
               end
            end
            ST_FIN: begin
               out_sample <= q_code;
               state      <= ST_HOLD;
            end
            ST_HOLD: begin
               if (out_ready) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state == ST_IDLE);
   assign out_valid = (state == ST_HOLD);

endmodule

// File: rtl/sine_poly_eval_chk.sv
module sine_poly_eval_chk
   import sine_poly_pkg::*;
#(
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_sample
);
   localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

   logic [7:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (in_valid && in_ready) begin
         busy_cnt <= '0;
      end else if (!in_ready && !out_valid) begin
         busy_cnt <= busy_cnt + 8'd1;
      end
   end

   AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);                                  // R2
   AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (busy_cnt == 8'(ACCEPT_TO_VALID)));                // R3
   AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));      // R4
   AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> !out_valid);                               // R4
   AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sample != MIN_CODE));                                // R8

endmodule

bind sine_poly_eval sine_poly_eval_chk #(
   .OUT_W (OUT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_sample (out_sample)
);

// File: tb/sine_poly_eval_tb.sv
module sine_poly_eval_tb;
   localparam int PW = 16;
   localparam int DW = 16;
   localparam int TOP = (1 << (DW - 1)) - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic [PW-1:0]        in_phase = '0;
   logic                 out_valid;
   logic                 out_ready = 1'b0;
   logic signed [DW-1:0] out_sample;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sine_poly_eval u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_phase   (in_phase),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_sample (out_sample)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_code(input int p);
      real a;
      real s;
      int  e;
      a = 2.0 * 3.14159265358979323846 * real'(p) / real'(1 << PW);
      s = $sin(a) * real'(1 << (DW - 1));
      e = (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
      if (e > TOP) e = TOP;
      if (e < -TOP) e = -TOP;
      return e;
   endfunction

   // offer one phase, wait for the sample, retire it
   task automatic run_one(input int p, output int got, output int lat, output bit busy_rdy);
      @(negedge clk);
      in_phase = PW'(p);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      lat = 0;
      busy_rdy = 1'b0;
      while (!out_valid) begin
         if (in_ready) busy_rdy = 1'b1;
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      got = int'(out_sample);
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
      check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
   endtask

   task automatic t_cardinal();
      int g, l;
      bit b;
      run_one(0, g, l, b);
      check(g == 0, "R9 phase zero", g, 0);
      run_one(1 << (PW - 1), g, l, b);
      check(g == 0, "R9 half turn", g, 0);
      run_one(1 << (PW - 2), g, l, b);
      check(g == TOP, "R8 quarter turn", g, TOP);
      run_one(3 << (PW - 2), g, l, b);
      check(g == -TOP, "R8 three quarters", g, -TOP);
   endtask

   task automatic t_latency();
      int g, l;
      bit b;
      run_one(12345, g, l, b);
      check(l == 10, "R3 accept to valid", l, 10);
      check(b == 1'b0, "R2 in_ready low while busy", int'(b), 0);
   endtask

   task automatic t_sweep();
      int g, l, e, p;
      bit b;
      for (int i = 0; i < 200; i++) begin
         p = (i * 331 + 7) % (1 << PW);
         run_one(p, g, l, b);
         e = ref_code(p);
         check((g - e <= 2) && (e - g <= 2), "R5 amplitude error", g, e);
      end
   endtask

   task automatic t_symmetry();
      int ga, gb, l;
      bit b;
      for (int i = 1; i < 12; i++) begin
         int d;
         d = i * 1237;
         run_one(d, ga, l, b);
         run_one(d + (1 << (PW - 1)), gb, l, b);
         check(gb == -ga, "R6 half-turn negation", gb, -ga);
         run_one((1 << (PW - 2)) - d, ga, l, b);
         run_one((1 << (PW - 2)) + d, gb, l, b);
         check(gb == ga, "R7 quarter reflection", gb, ga);
      end
   endtask

   task automatic t_backpressure();
      int first;
      @(negedge clk);
      in_phase = PW'(5000);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      while (!out_valid) begin
         @(posedge clk);
         @(negedge clk);
      end
      first = int'(out_sample);
      for (int i = 0; i < 6; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
      check(out_valid == 1'b1, "R4 valid held", int'(out_valid), 1);
      check(int'(out_sample) == first, "R4 sample held", int'(out_sample), first);
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      check(out_valid == 1'b0, "R4 retired", int'(out_valid), 0);
   endtask

   task automatic t_ignore_busy();
      int got, e, extra;
      @(negedge clk);
      in_phase = PW'(9000);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      // keep offering another phase while busy: must be ignored
      in_phase = PW'(40000);
      while (!out_valid) begin
         @(posedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
      got = int'(out_sample);
      e = ref_code(9000);
      check((got - e <= 2) && (e - got <= 2), "R2 first phase kept", got, e);
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      extra = 0;
      for (int i = 0; i < 20; i++) begin
         if (out_valid) extra++;
         @(posedge clk);
         @(negedge clk);
      end
      check(extra == 0, "R2 no sample from ignored phase", extra, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_cardinal();
      t_latency();
      t_sweep();
      t_symmetry();
      t_backpressure();
      t_ignore_busy();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule